// File: doc/BRIEF.md
# Transmit Buffer Byte Unpacker

This block turns one transmit buffer, stored as 16-bit words in a word-addressed memory, into a stream of bytes for a transmit FIFO. A start pulse supplies the first word address and the frame length in bytes. The block then reads the buffer one word at a time and presents the frame bytes in order on a valid/ready byte port. The final byte carries a last marker, and a one-cycle done pulse follows once that byte has been taken.

Each word carries two frame bytes, the earlier one in the low half. The number of words read and the position of the final word come from the byte count. An even count ends on the high byte of its last word. An odd count ends on the low byte of its last word, and the high half of that word is never sent. A static swap input reverses the byte order inside every word, for hosts that store data the other way round. The block keeps a small prefetch store of words, so a consumer that takes a byte every cycle is not starved. If the consumer does ask for a byte mid-frame and none is ready, an underrun flag is raised for that frame.

Counts of zero, and counts above the buffer capacity of 4096 bytes, are answered at once and cause no reads.

Top module: `txbuf_unpack`

## Requirements
- R1: After reset, outValid, outLast, memReq, done, lengthErr, underrun and busy are all low.
- R2: With swapBytes low, frame byte 2k is bits 7:0 of the word at address baseAddr+k, and frame byte 2k+1 is bits 15:8 of that word.
- R3: With swapBytes high, frame byte 2k is bits 15:8 of the word at baseAddr+k, and byte 2k+1 is bits 7:0 of that word.
- R4: For an even byte count N, exactly N bytes are emitted, the last word read is at baseAddr+(N-2)/2, and the final byte is that word's second byte.
- R5: For an odd byte count N, exactly N bytes are emitted, the last word read is at baseAddr+(N-1)/2, and only that word's first byte is sent.
- R6: Each read asserts memReq with memAddr for one cycle, and its data is taken from memData in the next cycle. A frame reads ceil(N/2) words, each exactly once, at ascending addresses starting at baseAddr. Addresses wrap modulo 2^ADDR_W.
- R7: While outValid is high and outReady is low, outValid stays high and outData and outLast hold their values into the next cycle.
- R8: outLast is high with the final byte only. done is high for exactly one cycle, the cycle after the final byte is accepted.
- R9: A start with a byte count of 0 raises done in the next cycle, issues no read, and leaves busy low.
- R10: A start with a byte count above 4096 raises lengthErr for one cycle in the next cycle. It issues no read, gives no done, and leaves busy low.
- R11: underrun is set when outReady is high and no byte is available during a frame in which at least one byte has already been accepted. It stays set until the next accepted start clears it. With the default prefetch of two words, a consumer that is always ready never triggers it.
- R12: A start pulse while busy is high is ignored, and the frame in progress completes unchanged.
- R13: A byte count of exactly 4096 is accepted and streams all 4096 bytes with no lengthErr.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame (ignored while busy) |
| baseAddr | input | ADDR_W | Word address of the first buffer word |
| byteCount | input | CNT_W | Frame length in bytes |
| swapBytes | input | 1 | Static: exchange the byte halves of each word |
| memReq | output | 1 | Word read request |
| memAddr | output | ADDR_W | Word read address |
| memData | input | 16 | Read data, valid in the cycle after memReq |
| outValid | output | 1 | A frame byte is offered |
| outReady | input | 1 | Consumer takes the offered byte |
| outData | output | 8 | Frame byte |
| outLast | output | 1 | Offered byte is the final one of the frame |
| done | output | 1 | One-cycle pulse after the final byte is taken, or after a zero-length start |
| lengthErr | output | 1 | One-cycle pulse for an over-length start |
| underrun | output | 1 | Consumer starved during the current or last frame |
| busy | output | 1 | A frame is in progress |

## Verification
The timing of each result is fixed by the registers in its path:
- done and lengthErr for a zero or over-length start are due in the cycle after the start edge.
- A word requested in one cycle is registered at the end of the next cycle and can be offered in the cycle after that.
- done after a frame is due exactly one cycle after the edge that accepts the byte flagged last.

The bench drives inputs at falling edges and samples every output at falling edges. The memory model answers one edge after each request. The monitor records the cycle number of the final acceptance and of done and compares them. A second instance with a one-word prefetch store is run on the same stimulus, so that an underrun can be provoked.

// File: rtl/txbuf_unpack_pkg.sv
package txbuf_unpack_pkg;

  // Strobes sent from the control to the datapath each cycle.
  typedef struct packed {
    logic loadBase;   // latch base address, clear offset and pointers
    logic issueRead;  // a word read goes out this cycle
    logic pushWord;   // memData holds a returned word this cycle
    logic popWord;    // head word fully consumed
    logic oddByte;    // select second byte of the head word
  } unpkStrobe_t;

endpackage

// File: rtl/txbuf_unpack_dp.sv
module txbuf_unpack_dp
  import txbuf_unpack_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  unpkStrobe_t       strb,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic              swapBytes,
  input  logic [15:0]       memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        outData
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] PTR_MAX = PW'(DEPTH - 1);

  logic [ADDR_W-1:0] baseQ;
  logic [ADDR_W-1:0] offQ;
  logic [PW-1:0]     wrPtr;
  logic [PW-1:0]     rdPtr;
  logic [15:0]       wordStore [DEPTH];
  logic [15:0]       headWord;
  logic [7:0]        firstByte;
  logic [7:0]        secondByte;

  // Address generation: base plus running word offset.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ <= '0;
      offQ  <= '0;
    end else if (strb.loadBase) begin
      baseQ <= baseAddr;
      offQ  <= '0;
    end else if (strb.issueRead) begin
      offQ  <= offQ + 1'b1;
    end
  end

  assign memAddr = baseQ + offQ;

  // Prefetch store pointers.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (strb.loadBase) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.pushWord) wrPtr <= (wrPtr == PTR_MAX) ? '0 : wrPtr + 1'b1;
      if (strb.popWord)  rdPtr <= (rdPtr == PTR_MAX) ? '0 : rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.pushWord) wordStore[wrPtr] <= memData;
  end

  assign headWord = wordStore[rdPtr];

  // Byte order within a word, selected statically.
  generate
    if (1) begin : g_order
      always_comb begin
        if (swapBytes) begin
          firstByte  = headWord[15:8];
          secondByte = headWord[7:0];
        end else begin
          firstByte  = headWord[7:0];
          secondByte = headWord[15:8];
        end
      end
    end
  endgenerate

  assign outData = strb.oddByte ? secondByte : firstByte;

endmodule

// File: rtl/txbuf_unpack_ctrl.sv
module txbuf_unpack_ctrl
  import txbuf_unpack_pkg::*;
#(
  parameter int MAX_WORDS = 2048,
  parameter int DEPTH     = 2,
  parameter int CNT_W     = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] byteCount,
  input  logic             outReady,
  output unpkStrobe_t      strb,
  output logic             outValid,
  output logic             outLast,
  output logic             done,
  output logic             lengthErr,
  output logic             underrun,
  output logic             busy
);

  localparam int MAX_BYTES = 2 * MAX_WORDS;
  localparam int WC_W      = $clog2(MAX_WORDS + 1);
  localparam int OCC_W     = $clog2(DEPTH + 1);

  logic             active;
  logic             rdPend;
  logic [OCC_W-1:0] occ;
  logic [CNT_W-1:0] byteIdx;
  logic [CNT_W-1:0] totalBytes;
  logic [WC_W-1:0]  wordsLeft;
  logic             doneQ;
  logic             errQ;
  logic             underQ;

  logic startOk, lenZero, lenBad, launch;
  logic room, issue, fire, lastB, pop;
  logic [CNT_W:0]   wordsNeed;

  assign startOk   = start && !active;
  assign lenZero   = (byteCount == '0);
  assign lenBad    = (byteCount > CNT_W'(MAX_BYTES));
  assign launch    = startOk && !lenZero && !lenBad;
  assign wordsNeed = ({1'b0, byteCount} + 1'b1) >> 1;

  assign room  = ((OCC_W+1)'(occ) + (OCC_W+1)'(rdPend)) < (OCC_W+1)'(DEPTH);
  assign issue = active && (wordsLeft != '0) && room;

  assign outValid = active && (occ != '0);
  assign lastB    = (byteIdx == totalBytes - 1'b1);
  assign outLast  = outValid && lastB;
  assign fire     = outValid && outReady;
  assign pop      = fire && (byteIdx[0] || lastB);

  always_comb begin
    strb           = '0;
    strb.loadBase  = launch;
    strb.issueRead = issue;
    strb.pushWord  = rdPend;
    strb.popWord   = pop;
    strb.oddByte   = byteIdx[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active     <= 1'b0;
      rdPend     <= 1'b0;
      occ        <= '0;
      byteIdx    <= '0;
      totalBytes <= '0;
      wordsLeft  <= '0;
      doneQ      <= 1'b0;
      errQ       <= 1'b0;
      underQ     <= 1'b0;
    end else begin
      doneQ  <= (startOk && lenZero) || (fire && lastB);
      errQ   <= startOk && lenBad;
      rdPend <= issue;
      if (launch) begin
        active     <= 1'b1;
        occ        <= '0;
        byteIdx    <= '0;
        totalBytes <= byteCount;
        wordsLeft  <= WC_W'(wordsNeed);
        underQ     <= 1'b0;
      end else begin
        occ <= occ + OCC_W'(rdPend) - OCC_W'(pop);
        if (issue) wordsLeft <= wordsLeft - 1'b1;
        if (fire) begin
          byteIdx <= byteIdx + 1'b1;
          if (lastB) active <= 1'b0;
        end
        if (active && (byteIdx != '0) && outReady && !outValid) underQ <= 1'b1;
      end
    end
  end

  assign done      = doneQ;
  assign lengthErr = errQ;
  assign underrun  = underQ;
  assign busy      = active;

  // R6
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (OCC_W+1)'(occ) + (OCC_W+1)'(rdPend) <= (OCC_W+1)'(DEPTH));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done || $past(startOk && lenZero));

  // R8
  last_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fire && outLast) |=> done && !busy);

  // R9
  zero_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && byteCount == '0) |=> done && !busy && !strb.issueRead);

  // R10
  len_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && byteCount > CNT_W'(MAX_BYTES)) |=> lengthErr && !busy && !done);

  // R7
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid && $stable(outLast));

endmodule

// File: rtl/txbuf_unpack.sv
module txbuf_unpack
  import txbuf_unpack_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int MAX_WORDS      = 2048,
  parameter int PREFETCH_WORDS = 2,
  localparam int CNT_W         = $clog2(2 * MAX_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic              swapBytes,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [15:0]       memData,
  output logic              outValid,
  input  logic              outReady,
  output logic [7:0]        outData,
  output logic              outLast,
  output logic              done,
  output logic              lengthErr,
  output logic              underrun,
  output logic              busy
);

  unpkStrobe_t strb;

  txbuf_unpack_ctrl #(
    .MAX_WORDS (MAX_WORDS),
    .DEPTH     (PREFETCH_WORDS),
    .CNT_W     (CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .byteCount (byteCount),
    .outReady  (outReady),
    .strb      (strb),
    .outValid  (outValid),
    .outLast   (outLast),
    .done      (done),
    .lengthErr (lengthErr),
    .underrun  (underrun),
    .busy      (busy)
  );

  txbuf_unpack_dp #(
    .ADDR_W (ADDR_W),
    .DEPTH  (PREFETCH_WORDS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .baseAddr  (baseAddr),
    .swapBytes (swapBytes),
    .memData   (memData),
    .memAddr   (memAddr),
    .outData   (outData)
  );

  assign memReq = strb.issueRead;

  // R7
  hold_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> $stable(outData));

endmodule

// File: tb/txbuf_unpack_test.sv
module txbuf_unpack_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int CW = 13;

  typedef struct packed {
    logic [15:0] base;
    logic [12:0] nbt;
    logic        swap;
    logic [1:0]  mode;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{16'h0100, 13'd8,  1'b0, 2'd0},
    '{16'h0200, 13'd7,  1'b0, 2'd0},
    '{16'h0300, 13'd1,  1'b0, 2'd1},
    '{16'h0400, 13'd2,  1'b0, 2'd2},
    '{16'h0500, 13'd9,  1'b1, 2'd1},
    '{16'h0600, 13'd12, 1'b1, 2'd2},
    '{16'hFFFE, 13'd6,  1'b0, 2'd0},
    '{16'h0700, 13'd33, 1'b0, 2'd1}
  };

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] baseAddr = '0;
  logic [CW-1:0] byteCount = '0;
  logic          swapBytes = 1'b0;
  logic          outReady = 1'b0;
  logic [15:0]   memData = '0;
  logic [15:0]   slowMemData = '0;
  logic          memReq, outValid, outLast, done, lengthErr, underrun, busy;
  logic [AW-1:0] memAddr;
  logic [7:0]    outData;
  logic          slowMemReq, slowValid, slowLast, slowDone, slowErr, slowUnderrun, slowBusy;
  logic [AW-1:0] slowMemAddr;
  logic [7:0]    slowData;

  txbuf_unpack uut (
    .clk(clk), .rstN(rstN), .start(start), .baseAddr(baseAddr), .byteCount(byteCount),
    .swapBytes(swapBytes), .memReq(memReq), .memAddr(memAddr), .memData(memData),
    .outValid(outValid), .outReady(outReady), .outData(outData), .outLast(outLast),
    .done(done), .lengthErr(lengthErr), .underrun(underrun), .busy(busy)
  );

  txbuf_unpack #(.PREFETCH_WORDS(1)) uutSlow (
    .clk(clk), .rstN(rstN), .start(start), .baseAddr(baseAddr), .byteCount(byteCount),
    .swapBytes(swapBytes), .memReq(slowMemReq), .memAddr(slowMemAddr), .memData(slowMemData),
    .outValid(slowValid), .outReady(outReady), .outData(slowData), .outLast(slowLast),
    .done(slowDone), .lengthErr(slowErr), .underrun(slowUnderrun), .busy(slowBusy)
  );

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;
  int readyMode = 0;
  int rc = 0;

  // monitor state
  logic [7:0]    cap [4200];
  int            capCnt, lastCnt, lastIdx, acceptCyc, doneCnt, doneCyc, errCnt;
  int            readCnt, orderErr, holdErr;
  logic [AW-1:0] expBase, lastRdAddr;
  logic          holdPend, holdLast;
  logic [7:0]    holdData;
  logic          reqS, sreqS;
  logic [AW-1:0] addrS, saddrS;

  function automatic logic [15:0] wordAt(input logic [AW-1:0] a);
    logic [7:0] lo, hi;
    lo = a[7:0] + 8'h31 + {a[11:8], 4'h0};
    hi = (a[7:0] ^ 8'hA5) + {4'h0, a[15:12]};
    return {hi, lo};
  endfunction

  function automatic logic [7:0] expByte(input logic [AW-1:0] b, input int i, input logic sw);
    logic [15:0] w;
    logic        takeHigh;
    w = wordAt(b + AW'(i / 2));
    takeHigh = ((i % 2) == 1) ^ sw;
    return takeHigh ? w[15:8] : w[7:0];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearMon();
    capCnt = 0; lastCnt = 0; lastIdx = -1; acceptCyc = -1; doneCnt = 0; doneCyc = -1;
    errCnt = 0; readCnt = 0; orderErr = 0; holdErr = 0; lastRdAddr = '0;
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: everything sampled at falling edges.
  initial begin
    clearMon();
    holdPend = 1'b0;
    forever begin
      @(negedge clk);
      reqS = memReq; addrS = memAddr;
      sreqS = slowMemReq; saddrS = slowMemAddr;
      if (rstN) begin
        if (memReq) begin
          if (memAddr !== expBase + AW'(readCnt)) orderErr++;
          lastRdAddr = memAddr;
          readCnt++;
        end
        if (holdPend && !(outValid && outData === holdData && outLast === holdLast)) holdErr++;
        holdPend = outValid && !outReady;
        holdData = outData;
        holdLast = outLast;
        if (outValid && outReady) begin
          if (capCnt < 4200) cap[capCnt] = outData;
          if (outLast) begin
            lastCnt++; lastIdx = capCnt; acceptCyc = cyc;
          end
          capCnt++;
        end
        if (done) begin doneCnt++; doneCyc = cyc; end
        if (lengthErr) errCnt++;
      end
    end
  end

  // Memory model: one-cycle read latency.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (reqS)  memData = wordAt(addrS);
      if (sreqS) slowMemData = wordAt(saddrS);
    end
  end

  // Consumer ready patterns.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      rc++;
      case (readyMode)
        0: outReady = 1'b1;
        1: outReady = rc[0];
        default: outReady = ((rc % 3) == 0);
      endcase
    end
  end

  initial begin
    wait (cyc > 150000);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  task automatic runFrame(input logic [AW-1:0] b, input int nbt, input logic sw, input int mode,
                          input string tagData, input string tagEnd, input bit interfere);
    int mism;
    @(posedge clk);
    clearMon();
    expBase = b;
    readyMode = mode;
    @(negedge clk);
    baseAddr = b; byteCount = CW'(nbt); swapBytes = sw; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (interfere && i == 5) begin
        @(negedge clk);
        baseAddr = 16'h3000; byteCount = 13'd5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
      if (doneCnt > 0 && !slowBusy) break;
    end
    repeat (3) @(negedge clk);
    @(posedge clk);
    mism = 0;
    for (int i = 0; i < nbt && i < capCnt && i < 4200; i++)
      if (cap[i] !== expByte(b, i, sw)) mism++;
    check(capCnt == nbt, tagEnd, capCnt, nbt);
    check(mism == 0, tagData, mism, 0);
    check(lastRdAddr == b + AW'((nbt - 1) / 2), tagEnd, int'(lastRdAddr), int'(b + AW'((nbt - 1) / 2)));
    check(readCnt == (nbt + 1) / 2 && orderErr == 0, "R6", readCnt, (nbt + 1) / 2);
    check(lastCnt == 1 && lastIdx == nbt - 1, "R8", lastIdx, nbt - 1);
    check(doneCnt == 1 && doneCyc == acceptCyc + 1, "R8", doneCyc - acceptCyc, 1);
    check(holdErr == 0, "R7", holdErr, 0);
    check(underrun == 1'b0, "R11", int'(underrun), 0);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!outValid && !memReq && !done && !busy && !lengthErr && !underrun && !outLast,
          "R1", int'({outValid, memReq, done, busy, lengthErr, underrun, outLast}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!outValid && !memReq && !done && !busy && !lengthErr && !underrun,
          "R1", int'({outValid, memReq, done, busy, lengthErr, underrun}), 0);

    // table of frames
    foreach (VECS[k]) begin
      runFrame(VECS[k].base, int'(VECS[k].nbt), VECS[k].swap, int'(VECS[k].mode),
               VECS[k].swap ? "R3" : "R2", VECS[k].nbt[0] ? "R5" : "R4", 1'b0);
    end

    // R9: zero length
    @(posedge clk);
    clearMon();
    @(negedge clk);
    byteCount = '0; baseAddr = 16'h0900; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b1 && busy == 1'b0, "R9", int'({done, busy}), 2);
    @(negedge clk);
    check(done == 1'b0, "R9", int'(done), 0);
    repeat (3) @(negedge clk);
    @(posedge clk);
    check(readCnt == 0 && doneCnt == 1, "R9", readCnt, 0);

    // R10: over-length counts
    @(posedge clk);
    clearMon();
    @(negedge clk);
    byteCount = 13'd4097; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(lengthErr == 1'b1 && busy == 1'b0, "R10", int'({lengthErr, busy}), 2);
    @(negedge clk);
    byteCount = 13'd8191; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(lengthErr == 1'b1, "R10", int'(lengthErr), 1);
    repeat (4) @(negedge clk);
    @(posedge clk);
    check(errCnt == 2 && doneCnt == 0 && readCnt == 0 && !busy, "R10", errCnt, 2);

    // R13: full-capacity buffer
    runFrame(16'h1000, 4096, 1'b0, 0, "R13", "R13", 1'b0);
    check(errCnt == 0, "R13", errCnt, 0);

    // R12: start while busy is ignored
    runFrame(16'h2000, 20, 1'b0, 2, "R12", "R12", 1'b1);

    // R11: underrun on a one-word prefetch instance, then cleared by next start
    runFrame(16'h4000, 8, 1'b0, 0, "R2", "R4", 1'b0);
    check(slowUnderrun == 1'b1, "R11", int'(slowUnderrun), 1);
    runFrame(16'h4100, 2, 1'b0, 0, "R2", "R4", 1'b0);
    check(slowUnderrun == 1'b0, "R11", int'(slowUnderrun), 0);

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule